// File: doc/BRIEF.md
# Multi-Port Region Access Checker

This block sits between a bus fabric and its slave ports and judges every access against a bank of memory region descriptors. Three ports are checked in parallel against the same descriptors. For each access it takes the address, the requesting master, whether the access is a write or an instruction fetch, and whether the master is in supervisor or user mode. Every valid region is compared at once, and the access is either forwarded to the slave or blocked and answered with an error response. The decision is made in the same cycle as the address phase, so a blocked access never reaches the slave.

Overlapping regions are combined so that a grant wins. An access is allowed if any region it falls in allows it. It is refused if it falls in no region, or if every region it falls in refuses it. Each port keeps a fault record holding the address and attributes of the last refused access. A record stays valid until it is cleared. A further fault overwrites it and flags an overrun. Clearing the global check enable lets every access through unchecked, which is useful while descriptors are loaded.

Top module: `region_guard`

## Requirements
- R1: A valid region is hit when start[31:5] <= addr[31:5] <= end[31:5], inclusive at both ends. Address bits [4:0] are ignored, and a region whose valid bit is 0 never hits.
- R2: Region r gives master m a 6-bit field at rgn_perm[(r*4+m)*6 +: 6]. Bit 0 is user read, bit 1 user write, bit 2 user execute, and bits 3 to 5 are the same three for supervisor. A fetch needs execute, otherwise a write needs write, otherwise read is needed.
- R3: When the address hits several regions, the access is allowed if at least one hit region grants it.
- R4: A checked access is refused when it hits no valid region, or when every region it hits denies it.
- R5: A refused access drives err_resp high and fwd_valid low in the same cycle as acc_valid. An allowed access drives fwd_valid high and err_resp low.
- R6: The three ports are judged independently and simultaneously. A refusal on one port does not affect another port.
- R7: After reset no record is valid. On a refusal, the port's record shows from the next cycle: flt_valid=1, flt_addr = the access address, and flt_detail = {hit mask[20:5], master[4:3], fetch[2], write[1], supervisor[0]}. Bit n of the hit mask is set when the address hit region n.
- R8: With chk_en=0, fwd_valid equals acc_valid, err_resp stays 0 and no record is captured.
- R9: A captured record is left unchanged by later allowed or idle cycles.
- R10: A refusal on a port whose record is already valid overwrites the record and sets flt_overrun.
- R11: flt_clear drops flt_valid and flt_overrun in the next cycle. If a refusal arrives in the same cycle, the new fault is captured with flt_overrun=0.
- R12: A single region can cover anything from one 32-byte granule up to the full 4 GB space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Global check enable |
| rgn_valid | input | 16 | Valid bit per region |
| rgn_start | input | 512 | Region start addresses, 32 bits per region |
| rgn_end | input | 512 | Region end addresses, 32 bits per region |
| rgn_perm | input | 384 | Permission fields, 6 bits per region per master |
| acc_valid | input | 3 | Address phase present, per port |
| acc_addr | input | 96 | Access address, per port |
| acc_master | input | 6 | Master ID, 2 bits per port |
| acc_write | input | 3 | Write access, per port |
| acc_fetch | input | 3 | Instruction fetch, per port |
| acc_super | input | 3 | Supervisor mode, per port |
| fwd_valid | output | 3 | Select toward the slave, per port |
| err_resp | output | 3 | Error response request, per port |
| flt_clear | input | 3 | Clear the fault record, per port |
| flt_valid | output | 3 | Fault record valid, per port |
| flt_overrun | output | 3 | A fault overwrote a valid record, per port |
| flt_addr | output | 96 | Faulting address, per port |
| flt_detail | output | 63 | Fault detail, 21 bits per port |

## Verification
The hardest state to reach is a fault that coincides with a record that is already valid. The overrun and the clear-versus-capture race in the same cycle both depend on it. The stimulus first parks a fault in the record and keeps it there through an allowed access. It then issues a second refusal, with and without flt_clear asserted, in the same cycle. Overlap behaviour is reached with two deliberately overlapping regions whose grants differ only by access type, so a single address can be allowed or refused depending on the access type.

// File: rtl/rg_pkg.sv
`timescale 1ns/1ps
package rg_pkg;
    // permission bits per master per region: user rwx then supervisor rwx
    localparam int PERM_W = 6;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e kind_of(input logic write, input logic fetch);
        if (fetch)      return KIND_EXEC;
        else if (write) return KIND_WRITE;
        else            return KIND_READ;
    endfunction
endpackage

// File: rtl/rg_region_match.sv
`timescale 1ns/1ps
module rg_region_match
    import rg_pkg::*;
#(
    parameter int AW   = 32,
    parameter int GRAN = 5,
    parameter int NM   = 4,
    parameter int MW   = 2
) (
    input  logic                 rgn_valid,
    input  logic [AW-1:0]        rgn_start,
    input  logic [AW-1:0]        rgn_end,
    input  logic [NM*PERM_W-1:0] rgn_perm,
    input  logic [AW-1:0]        addr,
    input  logic [MW-1:0]        master,
    input  acc_kind_e            kind,
    input  logic                 super_mode,
    output logic                 hit,
    output logic                 grant
);
    localparam int PW = AW - GRAN;

    logic [PW-1:0]     page_a, page_s, page_e;
    logic [PERM_W-1:0] field;
    logic [2:0]        rwx;
    logic              unused_lo;

    assign page_a    = addr[AW-1:GRAN];
    assign page_s    = rgn_start[AW-1:GRAN];
    assign page_e    = rgn_end[AW-1:GRAN];
    assign unused_lo = ^{addr[GRAN-1:0], rgn_start[GRAN-1:0], rgn_end[GRAN-1:0]};

    always_comb begin
        hit   = rgn_valid && (page_a >= page_s) && (page_a <= page_e);
        field = rgn_perm[int'(master)*PERM_W +: PERM_W];
        rwx   = super_mode ? field[5:3] : field[2:0];
        grant = hit && rwx[int'(kind)];
    end
endmodule

// File: rtl/rg_port_check.sv
`timescale 1ns/1ps
module rg_port_check
    import rg_pkg::*;
#(
    parameter int AW   = 32,
    parameter int GRAN = 5,
    parameter int NR   = 16,
    parameter int NM   = 4,
    parameter int MW   = 2
) (
    input  logic                    chk_en,
    input  logic [NR-1:0]           rgn_valid,
    input  logic [NR*AW-1:0]        rgn_start,
    input  logic [NR*AW-1:0]        rgn_end,
    input  logic [NR*NM*PERM_W-1:0] rgn_perm,
    input  logic                    acc_valid,
    input  logic [AW-1:0]           addr,
    input  logic [MW-1:0]           master,
    input  logic                    write,
    input  logic                    fetch,
    input  logic                    super_mode,
    output logic                    fwd,
    output logic                    err,
    output logic [NR-1:0]           hit_mask
);
    localparam int RPW = NM * PERM_W;

    acc_kind_e     kind;
    logic [NR-1:0] grant_vec;
    logic          allow;

    assign kind = kind_of(write, fetch);

    for (genvar r = 0; r < NR; r++) begin : g_rgn
        rg_region_match #(
            .AW(AW), .GRAN(GRAN), .NM(NM), .MW(MW)
        ) u_match (
            .rgn_valid (rgn_valid[r]),
            .rgn_start (rgn_start[r*AW +: AW]),
            .rgn_end   (rgn_end[r*AW +: AW]),
            .rgn_perm  (rgn_perm[r*RPW +: RPW]),
            .addr      (addr),
            .master    (master),
            .kind      (kind),
            .super_mode(super_mode),
            .hit       (hit_mask[r]),
            .grant     (grant_vec[r])
        );
    end

    always_comb begin
        // any granting region wins over denying ones
        allow = |grant_vec;
        fwd   = acc_valid && (!chk_en || allow);
        err   = acc_valid && chk_en && !allow;
    end
endmodule

// File: rtl/rg_fault_rec.sv
`timescale 1ns/1ps
module rg_fault_rec #(
    parameter int AW = 32,
    parameter int DW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          clear,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] detail,
    output logic          rec_valid,
    output logic          rec_overrun,
    output logic [AW-1:0] rec_addr,
    output logic [DW-1:0] rec_detail
);
    typedef struct packed {
        logic          valid;
        logic          overrun;
        logic [AW-1:0] addr;
        logic [DW-1:0] detail;
    } rec_t;

    rec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.valid   = 1'b0;
            st_d.overrun = 1'b0;
        end
        if (capture) begin
            st_d.overrun = st_q.valid && !clear;
            st_d.valid   = 1'b1;
            st_d.addr    = addr;
            st_d.detail  = detail;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rec_valid   = st_q.valid;
    assign rec_overrun = st_q.overrun;
    assign rec_addr    = st_q.addr;
    assign rec_detail  = st_q.detail;
endmodule

// File: rtl/region_guard.sv
`timescale 1ns/1ps
module region_guard
    import rg_pkg::*;
#(
    parameter int NUM_PORTS   = 3,
    parameter int NUM_REGIONS = 16,
    parameter int NUM_MASTERS = 4,
    parameter int AW          = 32,
    parameter int GRAN        = 5,
    parameter int MW          = $clog2(NUM_MASTERS),
    parameter int DW          = NUM_REGIONS + MW + 3
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    chk_en,
    input  logic [NUM_REGIONS-1:0]                  rgn_valid,
    input  logic [NUM_REGIONS*AW-1:0]               rgn_start,
    input  logic [NUM_REGIONS*AW-1:0]               rgn_end,
    input  logic [NUM_REGIONS*NUM_MASTERS*PERM_W-1:0] rgn_perm,
    input  logic [NUM_PORTS-1:0]                    acc_valid,
    input  logic [NUM_PORTS*AW-1:0]                 acc_addr,
    input  logic [NUM_PORTS*MW-1:0]                 acc_master,
    input  logic [NUM_PORTS-1:0]                    acc_write,
    input  logic [NUM_PORTS-1:0]                    acc_fetch,
    input  logic [NUM_PORTS-1:0]                    acc_super,
    output logic [NUM_PORTS-1:0]                    fwd_valid,
    output logic [NUM_PORTS-1:0]                    err_resp,
    input  logic [NUM_PORTS-1:0]                    flt_clear,
    output logic [NUM_PORTS-1:0]                    flt_valid,
    output logic [NUM_PORTS-1:0]                    flt_overrun,
    output logic [NUM_PORTS*AW-1:0]                 flt_addr,
    output logic [NUM_PORTS*DW-1:0]                 flt_detail
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [NUM_REGIONS-1:0] hit_mask;
        logic [DW-1:0]          detail;

        rg_port_check #(
            .AW(AW), .GRAN(GRAN), .NR(NUM_REGIONS), .NM(NUM_MASTERS), .MW(MW)
        ) u_check (
            .chk_en    (chk_en),
            .rgn_valid (rgn_valid),
            .rgn_start (rgn_start),
            .rgn_end   (rgn_end),
            .rgn_perm  (rgn_perm),
            .acc_valid (acc_valid[p]),
            .addr      (acc_addr[p*AW +: AW]),
            .master    (acc_master[p*MW +: MW]),
            .write     (acc_write[p]),
            .fetch     (acc_fetch[p]),
            .super_mode(acc_super[p]),
            .fwd       (fwd_valid[p]),
            .err       (err_resp[p]),
            .hit_mask  (hit_mask)
        );

        assign detail = {hit_mask, acc_master[p*MW +: MW],
                         acc_fetch[p], acc_write[p], acc_super[p]};

        rg_fault_rec #(
            .AW(AW), .DW(DW)
        ) u_rec (
            .clk        (clk),
            .rst_n      (rst_n),
            .capture    (err_resp[p]),
            .clear      (flt_clear[p]),
            .addr       (acc_addr[p*AW +: AW]),
            .detail     (detail),
            .rec_valid  (flt_valid[p]),
            .rec_overrun(flt_overrun[p]),
            .rec_addr   (flt_addr[p*AW +: AW]),
            .rec_detail (flt_detail[p*DW +: DW])
        );
    end
endmodule

// File: rtl/region_guard_chk.sv
`timescale 1ns/1ps
module region_guard_chk #(
    parameter int NP = 3,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chk_en,
    input logic [NP-1:0] acc_valid,
    input logic [NP-1:0] fwd_valid,
    input logic [NP-1:0] err_resp,
    input logic [NP-1:0] flt_clear,
    input logic [NP-1:0] flt_valid,
    input logic [NP-1:0] flt_overrun,
    input logic [NP*AW-1:0] flt_addr
);
    for (genvar p = 0; p < NP; p++) begin : g_p
        AST_ERR_BLOCKS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
            err_resp[p] |-> !fwd_valid[p]); // R5
        AST_BYPASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !chk_en |-> (fwd_valid[p] == acc_valid[p]) && !err_resp[p]); // R8
        AST_FAULT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
            err_resp[p] |=> flt_valid[p]); // R7
        AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !err_resp[p] && !flt_clear[p] |=> $stable(flt_addr[p*AW +: AW]) && $stable(flt_valid[p])); // R9
        AST_OVERRUN_ON_REFAULT: assert property (@(posedge clk) disable iff (!rst_n)
            err_resp[p] && flt_valid[p] && !flt_clear[p] |=> flt_overrun[p]); // R10
        AST_OVERRUN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            flt_overrun[p] |-> flt_valid[p]); // R10
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            flt_clear[p] && !err_resp[p] |=> !flt_valid[p] && !flt_overrun[p]); // R11
        AST_CLEAR_RACE: assert property (@(posedge clk) disable iff (!rst_n)
            flt_clear[p] && err_resp[p] |=> flt_valid[p] && !flt_overrun[p]); // R11
    end
endmodule

bind region_guard region_guard_chk #(
    .NP(NUM_PORTS), .AW(AW)
) u_region_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (chk_en),
    .acc_valid  (acc_valid),
    .fwd_valid  (fwd_valid),
    .err_resp   (err_resp),
    .flt_clear  (flt_clear),
    .flt_valid  (flt_valid),
    .flt_overrun(flt_overrun),
    .flt_addr   (flt_addr)
);

// File: tb/test_region_guard.sv
`timescale 1ns/1ps
module test_region_guard;
    localparam int NP = 3, NR = 16, NM = 4, AW = 32, MW = 2, DW = 21, PW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_en;
    logic [NR-1:0]       rgn_valid;
    logic [NR*AW-1:0]    rgn_start, rgn_end;
    logic [NR*NM*PW-1:0] rgn_perm;
    logic [NP-1:0]       acc_valid, acc_write, acc_fetch, acc_super, flt_clear;
    logic [NP*AW-1:0]    acc_addr;
    logic [NP*MW-1:0]    acc_master;
    logic [NP-1:0]       fwd_valid, err_resp, flt_valid, flt_overrun;
    logic [NP*AW-1:0]    flt_addr;
    logic [NP*DW-1:0]    flt_detail;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    region_guard i_region_guard (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
        .rgn_valid(rgn_valid), .rgn_start(rgn_start), .rgn_end(rgn_end), .rgn_perm(rgn_perm),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_master(acc_master),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_super(acc_super),
        .fwd_valid(fwd_valid), .err_resp(err_resp), .flt_clear(flt_clear),
        .flt_valid(flt_valid), .flt_overrun(flt_overrun),
        .flt_addr(flt_addr), .flt_detail(flt_detail)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] det(input logic [15:0] mask, input logic [1:0] m,
                                          input logic f, input logic w, input logic s);
        return {mask, m, f, w, s};
    endfunction

    task automatic set_rgn(input int r, input logic [31:0] s, input logic [31:0] e, input logic v);
        rgn_start[r*AW +: AW] = s;
        rgn_end[r*AW +: AW]   = e;
        rgn_valid[r]          = v;
    endtask

    task automatic set_perm(input int r, input int m, input logic [5:0] bits);
        rgn_perm[(r*NM+m)*PW +: PW] = bits;
    endtask

    task automatic drive(input int p, input logic [31:0] a, input logic [1:0] m,
                         input logic w, input logic f, input logic s);
        acc_valid[p] = 1'b1;
        acc_addr[p*AW +: AW] = a;
        acc_master[p*MW +: MW] = m;
        acc_write[p] = w;
        acc_fetch[p] = f;
        acc_super[p] = s;
    endtask

    task automatic idle();
        acc_valid = '0; acc_write = '0; acc_fetch = '0; acc_super = '0;
        acc_addr = '0; acc_master = '0; flt_clear = '0;
    endtask

    // advance one edge and land mid low phase with inputs idled
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic clear_all();
        flt_clear = '1;
        tick();
    endtask

    // one access on one port: check comb decision, then the record
    task automatic one(input string tag, input int p, input logic [31:0] a, input logic [1:0] m,
                       input logic w, input logic f, input logic s,
                       input logic exp_ok, input logic [15:0] exp_mask);
        drive(p, a, m, w, f, s);
        #1;
        chk({tag, " fwd"}, 64'(fwd_valid[p]), 64'(exp_ok));
        chk({tag, " err"}, 64'(err_resp[p]), 64'(!exp_ok));
        tick();
        chk({tag, " rec valid"}, 64'(flt_valid[p]), 64'(!exp_ok));
        if (!exp_ok) begin
            chk({tag, " rec addr"}, 64'(flt_addr[p*AW +: AW]), 64'(a));
            chk({tag, " rec detail"}, 64'(flt_detail[p*DW +: DW]), 64'(det(exp_mask, m, f, w, s)));
        end
        clear_all();
    endtask

    task automatic t_reset();
        chk("R7 reset valid", 64'(flt_valid), 64'(0));
        chk("R7 reset overrun", 64'(flt_overrun), 64'(0));
        chk("R5 reset fwd", 64'(fwd_valid), 64'(0));
        chk("R5 reset err", 64'(err_resp), 64'(0));
    endtask

    task automatic t_perms();
        one("R2 m0 sup read", 0, 32'h0000_0100, 2'd0, 0, 0, 1, 1'b1, 16'h0);
        one("R2 m0 usr read", 0, 32'h0000_0100, 2'd0, 0, 0, 0, 1'b1, 16'h0);
        one("R2 R4 R5 m0 usr write deny", 0, 32'h0000_4000, 2'd0, 1, 0, 0, 1'b0, 16'h0001);
        one("R2 m0 usr fetch deny", 1, 32'h0000_0100, 2'd0, 0, 1, 0, 1'b0, 16'h0001);
        one("R2 m0 sup fetch", 1, 32'h0000_0100, 2'd0, 0, 1, 1, 1'b1, 16'h0);
        one("R2 m1 no perms", 2, 32'h0000_0100, 2'd1, 0, 0, 1, 1'b0, 16'h0001);
        one("R2 fetch beats write", 0, 32'h0000_0100, 2'd0, 1, 1, 0, 1'b0, 16'h0001);
    endtask

    task automatic t_overlap();
        one("R3 overlap grant wins", 0, 32'h0000_9000, 2'd0, 1, 0, 0, 1'b1, 16'h0);
        one("R4 overlap all deny", 0, 32'h0000_9000, 2'd0, 0, 1, 0, 1'b0, 16'h0003);
        one("R3 second region only", 1, 32'h0001_2000, 2'd0, 1, 0, 0, 1'b1, 16'h0);
    endtask

    task automatic t_bounds();
        one("R1 granule top", 0, 32'h2000_001F, 2'd1, 0, 0, 0, 1'b1, 16'h0);
        one("R1 granule base", 0, 32'h2000_0000, 2'd1, 0, 0, 0, 1'b1, 16'h0);
        one("R1 R4 just above", 0, 32'h2000_0020, 2'd1, 0, 0, 0, 1'b0, 16'h0000);
        one("R1 R4 just below", 0, 32'h1FFF_FFFF, 2'd1, 0, 0, 0, 1'b0, 16'h0000);
        one("R1 end low bits ignored", 0, 32'h0000_FFFF, 2'd0, 0, 0, 0, 1'b1, 16'h0);
    endtask

    task automatic t_full();
        one("R1 invalid no hit", 2, 32'hDEAD_BEEC, 2'd3, 1, 0, 0, 1'b0, 16'h0000);
        rgn_valid[3] = 1'b1;
        one("R12 full space mid", 2, 32'hDEAD_BEEC, 2'd3, 1, 0, 0, 1'b1, 16'h0);
        one("R12 full space low", 2, 32'h0000_0000, 2'd3, 0, 1, 0, 1'b1, 16'h0);
        one("R12 full space high", 2, 32'hFFFF_FFFF, 2'd3, 0, 0, 0, 1'b1, 16'h0);
        rgn_valid[3] = 1'b0;
    endtask

    task automatic t_ports();
        drive(0, 32'h0000_0100, 2'd0, 0, 0, 1);
        drive(1, 32'h2000_0004, 2'd1, 0, 0, 0);
        drive(2, 32'h0000_0100, 2'd2, 0, 0, 0);
        #1;
        chk("R6 port0 fwd", 64'(fwd_valid), 64'(3'b011));
        chk("R6 port err", 64'(err_resp), 64'(3'b100));
        tick();
        chk("R6 only port2 rec", 64'(flt_valid), 64'(3'b100));
        chk("R6 R7 port2 detail", 64'(flt_detail[2*DW +: DW]), 64'(det(16'h0001, 2'd2, 0, 0, 0)));
        clear_all();
    endtask

    task automatic t_disable();
        chk_en = 1'b0;
        drive(0, 32'h5000_0000, 2'd2, 1, 0, 0);
        #1;
        chk("R8 off fwd", 64'(fwd_valid[0]), 64'(1));
        chk("R8 off err", 64'(err_resp[0]), 64'(0));
        tick();
        chk("R8 off no capture", 64'(flt_valid), 64'(0));
        #1;
        chk("R8 off idle fwd", 64'(fwd_valid), 64'(0));
        chk_en = 1'b1;
        #1;
        drive(0, 32'h5000_0000, 2'd2, 1, 0, 0);
        #1;
        chk("R8 on again err", 64'(err_resp[0]), 64'(1));
        tick();
        clear_all();
    endtask

    task automatic t_hold_overrun();
        drive(1, 32'h3000_0000, 2'd1, 0, 0, 0);
        tick();
        drive(1, 32'h2000_0000, 2'd1, 0, 0, 0);
        tick();
        tick();
        chk("R9 addr held", 64'(flt_addr[AW +: AW]), 64'(32'h3000_0000));
        chk("R9 valid held", 64'(flt_valid[1]), 64'(1));
        chk("R9 no overrun yet", 64'(flt_overrun[1]), 64'(0));
        drive(1, 32'h3000_0040, 2'd1, 1, 0, 1);
        tick();
        chk("R10 overwritten addr", 64'(flt_addr[AW +: AW]), 64'(32'h3000_0040));
        chk("R10 overwritten detail", 64'(flt_detail[DW +: DW]), 64'(det(16'h0000, 2'd1, 0, 1, 1)));
        chk("R10 overrun set", 64'(flt_overrun[1]), 64'(1));
        chk("R10 still valid", 64'(flt_valid[1]), 64'(1));
    endtask

    task automatic t_clear();
        flt_clear[1] = 1'b1;
        tick();
        chk("R11 clear valid", 64'(flt_valid[1]), 64'(0));
        chk("R11 clear overrun", 64'(flt_overrun[1]), 64'(0));
        drive(1, 32'h3000_0080, 2'd1, 0, 0, 0);
        tick();
        drive(1, 32'h3000_00C0, 2'd1, 0, 0, 0);
        flt_clear[1] = 1'b1;
        tick();
        chk("R11 race valid", 64'(flt_valid[1]), 64'(1));
        chk("R11 race overrun", 64'(flt_overrun[1]), 64'(0));
        chk("R11 race addr", 64'(flt_addr[AW +: AW]), 64'(32'h3000_00C0));
        drive(1, 32'h3000_0100, 2'd1, 0, 0, 0);
        tick();
        chk("R10 R11 refault overrun", 64'(flt_overrun[1]), 64'(1));
        clear_all();
        chk("R11 final clear", 64'(flt_valid), 64'(0));
    endtask

    initial begin
        chk_en = 1'b1;
        rgn_valid = '0; rgn_start = '0; rgn_end = '0; rgn_perm = '0;
        idle();
        set_rgn(0, 32'h0000_0000, 32'h0000_FFE0, 1'b1);
        set_perm(0, 0, 6'b111_001);
        set_rgn(1, 32'h0000_8000, 32'h0001_FFE0, 1'b1);
        set_perm(1, 0, 6'b000_010);
        set_rgn(2, 32'h2000_0000, 32'h2000_0000, 1'b1);
        set_perm(2, 1, 6'b000_001);
        set_rgn(3, 32'h0000_0000, 32'hFFFF_FFE0, 1'b0);
        set_perm(3, 3, 6'b000_111);
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_perms();
        t_overlap();
        t_bounds();
        t_full();
        t_ports();
        t_disable();
        t_hold_overrun();
        t_clear();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule